// File: doc/BRIEF.md
# Subaddress-Gated Display RAM Writer

This block takes decoded commands from a serial command front end and writes them into a small display memory. Each memory word is 4 bits wide. A command transaction opens with a start pulse. At that pulse the block samples the 3-bit hardware address pins. While the transaction is open, the block accepts five commands:

- a device-select command, which loads a 3-bit subaddress register;
- a load-pointer command, which moves the write pointer;
- a drive-mode command;
- an input-bank command;
- an output-bank command.

Data bytes reach the memory only when the subaddress register equals the sampled hardware address. This is how several identical blocks on one bus are told apart. Every data byte advances the pointer, whether or not it was stored. After a device is reselected, software must load the pointer again.

Each data byte updates one memory word. The drive mode sets how many low bits of the byte are used. In static and 1:2 modes, the input-bank setting picks the lower or the upper bit positions of the word. The bits outside the written positions keep their value. A plain asynchronous read port lets the display side read the memory.

A small state machine sits at the centre. It has two states:

- `TXN_IDLE`: no transaction is open.
- `TXN_OPEN`: a transaction is open.

Its transitions are:

- **open**: `TXN_IDLE` to `TXN_OPEN` on `txn_start`. The hardware address is sampled.
- **restart**: `TXN_OPEN` to `TXN_OPEN` on `txn_start`. The hardware address is sampled again.
- **close**: `TXN_OPEN` to `TXN_IDLE` on `txn_stop` without `txn_start`.
- **hold**: in either state, when there is no pulse.

Commands are decoded only in `TXN_OPEN`.

Top module: `dram_writer`

## Requirements
- R1: After reset the pointer is 0, the subaddress register is 0, both bank settings are 0, the drive mode is 1:4, every memory word reads 0, and `txn_active` is 0.
- R2: A device-select command (`cmd_op`=1) loads the subaddress register from `cmd_arg[2:0]`. A data byte is stored only when the subaddress register equals the hardware address sampled at the start of the transaction.
- R3: A data byte (`cmd_op`=0) always advances the pointer by one. When the subaddress does not match, the memory word is left unchanged.
- R4: A load-pointer command (`cmd_op`=2) sets the pointer to `cmd_arg` when `cmd_arg` is below 40. Larger values are ignored. The pointer wraps from 39 to 0.
- R5: The drive-mode command (`cmd_op`=3) selects the mode from `cmd_arg[1:0]`: 0 static, 1 1:2, 2 1:3, 3 1:4. In static mode, `cmd_arg[0]` is written to word bit 0 when the input bank is 0, or to word bit 2 when it is 1. The other bits are kept.
- R6: In 1:2 mode, `cmd_arg[1:0]` is written to word bits 1:0 when the input bank is 0, or to bits 3:2 when it is 1. The other bits are kept.
- R7: In 1:3 mode, `cmd_arg[2:0]` is written to word bits 2:0 and bit 3 is kept. In 1:4 mode, `cmd_arg[3:0]` replaces the whole word. In both modes the input bank has no effect.
- R8: The input-bank command (`cmd_op`=4) and the output-bank command (`cmd_op`=5) each load their own setting from `cmd_arg[0]`. Neither command changes the other setting. The output-bank setting is shown on `out_bank`.
- R9: The hardware address is sampled only on `txn_start`. Changing the pins while a transaction is open has no effect on gating.
- R10: Commands presented while no transaction is open are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_addr | input | 3 | Hardware address pins |
| txn_start | input | 1 | Opens a transaction and samples `hw_addr` |
| txn_stop | input | 1 | Closes the transaction |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Command code |
| cmd_arg | input | 8 | Command argument or data byte |
| rd_addr | input | 6 | Display read address |
| rd_data | output | 4 | Word at `rd_addr`, or 0 when `rd_addr` is out of range |
| data_ptr | output | 6 | Current write pointer |
| out_bank | output | 1 | Output-bank setting |
| txn_active | output | 1 | Transaction open |

## Verification
The same memory word is rewritten in each drive mode and each bank setting, with arguments that set and then clear single bits. This separates a wrong bit-plane mask from a failure to keep the untouched bits. The stimulus first drives matched bytes and then mismatched bytes at a known word. Comparing the stored word with the pointer shows whether a byte was blocked or lost while the pointer still advanced. Pointer loads at 39, 40 and 63 tell the wrap from the range check. Changing the address pins during an open transaction, and then reopening with the new value, shows that gating uses only the sampled address.

// File: rtl/dram_writer_pkg.sv
package dram_writer_pkg;

    typedef enum logic [2:0] {
        OP_DATA    = 3'd0,
        OP_DEVSEL  = 3'd1,
        OP_LOADPTR = 3'd2,
        OP_MODE    = 3'd3,
        OP_INBANK  = 3'd4,
        OP_OUTBANK = 3'd5
    } op_e;

    typedef enum logic [1:0] {
        MODE_STATIC = 2'd0,
        MODE_MUX2   = 2'd1,
        MODE_MUX3   = 2'd2,
        MODE_MUX4   = 2'd3
    } mode_e;

    typedef enum logic {
        TXN_IDLE = 1'b0,
        TXN_OPEN = 1'b1
    } txn_state_e;

    typedef struct packed {
        logic data;
        logic devsel;
        logic loadptr;
        logic mode;
        logic inbank;
        logic outbank;
    } strobe_t;

endpackage

// File: rtl/dram_txn_fsm.sv
module dram_txn_fsm
    import dram_writer_pkg::*;
#(
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          txn_start,
    input  logic          txn_stop,
    input  logic          cmd_valid,
    input  logic [2:0]    cmd_op,
    input  logic [AW-1:0] hw_addr,
    output logic          txn_active,
    output logic [AW-1:0] hw_latched,
    output strobe_t       stb
);

    txn_state_e state_q, state_d;

    // state register, plus the address sample taken on open or restart
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= TXN_IDLE;
            hw_latched <= '0;
        end else begin
            state_q <= state_d;
            if (txn_start) hw_latched <= hw_addr;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TXN_IDLE: if (txn_start) state_d = TXN_OPEN;
            TXN_OPEN: if (!txn_start && txn_stop) state_d = TXN_IDLE;
            default:  state_d = TXN_IDLE;
        endcase
    end

    // outputs: command strobes are decoded only in an open transaction
    always_comb begin
        stb        = '0;
        txn_active = (state_q == TXN_OPEN);
        if (state_q == TXN_OPEN && cmd_valid) begin
            unique case (cmd_op)
                OP_DATA:    stb.data    = 1'b1;
                OP_DEVSEL:  stb.devsel  = 1'b1;
                OP_LOADPTR: stb.loadptr = 1'b1;
                OP_MODE:    stb.mode    = 1'b1;
                OP_INBANK:  stb.inbank  = 1'b1;
                OP_OUTBANK: stb.outbank = 1'b1;
                default:    stb         = '0;
            endcase
        end
    end

    // R9: the sampled address holds for as long as no new start arrives
    p_hw_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !txn_start |=> $stable(hw_latched));

    // R10: no strobe while idle
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !txn_active |-> (stb == '0));

endmodule

// File: rtl/dram_ptr_ctrl.sv
module dram_ptr_ctrl
    import dram_writer_pkg::*;
#(
    parameter int DEPTH = 40,
    parameter int AW    = 3,
    parameter int PW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  strobe_t       stb,
    input  logic [7:0]    cmd_arg,
    input  logic [AW-1:0] hw_latched,
    output logic [PW-1:0] ptr,
    output logic          wr_en,
    output mode_e         mode,
    output logic          in_bank,
    output logic          out_bank
);

    localparam logic [7:0]    DEPTH_B = 8'(DEPTH);
    localparam logic [PW-1:0] LAST_P  = PW'(DEPTH - 1);

    logic [AW-1:0] subaddr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr      <= '0;
            subaddr  <= '0;
            mode     <= MODE_MUX4;
            in_bank  <= 1'b0;
            out_bank <= 1'b0;
        end else begin
            if (stb.devsel)  subaddr  <= cmd_arg[AW-1:0];
            if (stb.mode)    mode     <= mode_e'(cmd_arg[1:0]);
            if (stb.inbank)  in_bank  <= cmd_arg[0];
            if (stb.outbank) out_bank <= cmd_arg[0];
            if (stb.loadptr && cmd_arg < DEPTH_B)
                ptr <= cmd_arg[PW-1:0];
            else if (stb.data)
                ptr <= (ptr == LAST_P) ? '0 : ptr + 1'b1;
        end
    end

    assign wr_en = stb.data && (subaddr == hw_latched);

    // R3: every data byte moves the pointer by exactly one, wrapping at the end
    p_ptr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        stb.data |=> ptr == (($past(ptr) == LAST_P) ? '0 : $past(ptr) + 1'b1));

    // R4: the pointer never leaves the memory range
    p_ptr_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ptr <= LAST_P);

    // R8: an input-bank command leaves the output bank alone
    p_outbank_indep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stb.inbank && !stb.outbank) |=> $stable(out_bank));

endmodule

// File: rtl/dram_bank_steer.sv
module dram_bank_steer
    import dram_writer_pkg::*;
(
    input  mode_e       mode,
    input  logic        in_bank,
    input  logic [3:0]  data_lo,
    input  logic [3:0]  old_word,
    output logic [3:0]  mask,
    output logic [3:0]  new_word
);

    logic [3:0] val;

    always_comb begin
        unique case (mode)
            MODE_STATIC: begin
                mask = in_bank ? 4'b0100 : 4'b0001;
                val  = {4{data_lo[0]}};
            end
            MODE_MUX2: begin
                mask = in_bank ? 4'b1100 : 4'b0011;
                val  = {2{data_lo[1:0]}};
            end
            MODE_MUX3: begin
                mask = 4'b0111;
                val  = data_lo;
            end
            default: begin
                mask = 4'b1111;
                val  = data_lo;
            end
        endcase
        new_word = (old_word & ~mask) | (val & mask);
    end

endmodule

// File: rtl/dram_store.sv
module dram_store #(
    parameter int DEPTH = 40,
    parameter int WW    = 4,
    parameter int PW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [PW-1:0] waddr,
    input  logic [WW-1:0] wdata,
    output logic [WW-1:0] wold,
    input  logic [PW-1:0] raddr,
    output logic [WW-1:0] rdata
);

    localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

    logic [WW-1:0] mem [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem[i] <= '0;
            else if (we && waddr == PW'(i))
                mem[i] <= wdata;
        end
    end

    assign wold  = (waddr < DEPTH_P) ? mem[waddr] : '0;
    assign rdata = (raddr < DEPTH_P) ? mem[raddr] : '0;

    // R4: writes only land inside the memory
    p_waddr_ok_r4: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> waddr < DEPTH_P);

endmodule

// File: rtl/dram_writer.sv
module dram_writer
    import dram_writer_pkg::*;
#(
    parameter int DEPTH = 40,
    parameter int AW    = 3,
    parameter int PW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] hw_addr,
    input  logic          txn_start,
    input  logic          txn_stop,
    input  logic          cmd_valid,
    input  logic [2:0]    cmd_op,
    input  logic [7:0]    cmd_arg,
    input  logic [PW-1:0] rd_addr,
    output logic [3:0]    rd_data,
    output logic [PW-1:0] data_ptr,
    output logic          out_bank,
    output logic          txn_active
);

    localparam int WW = 4;

    strobe_t       stb;
    logic [AW-1:0] hw_latched;
    logic          wr_en;
    mode_e         mode;
    logic          in_bank;
    logic [WW-1:0] old_word, new_word, mask;

    dram_txn_fsm #(.AW(AW)) u_fsm (
        .clk, .rst_n, .txn_start, .txn_stop, .cmd_valid, .cmd_op, .hw_addr,
        .txn_active, .hw_latched, .stb
    );

    dram_ptr_ctrl #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_ctrl (
        .clk, .rst_n, .stb, .cmd_arg, .hw_latched,
        .ptr(data_ptr), .wr_en, .mode, .in_bank, .out_bank
    );

    dram_bank_steer u_steer (
        .mode, .in_bank, .data_lo(cmd_arg[3:0]), .old_word,
        .mask, .new_word
    );

    dram_store #(.DEPTH(DEPTH), .WW(WW), .PW(PW)) u_store (
        .clk, .rst_n, .we(wr_en), .waddr(data_ptr), .wdata(new_word),
        .wold(old_word), .raddr(rd_addr), .rdata(rd_data)
    );

    // R5: static writes touch exactly one of bit 0 or bit 2
    p_static_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && mode == MODE_STATIC) |-> (mask == 4'b0001 || mask == 4'b0100));

    // R7: 1:3 writes never change bit 3 of the word
    p_mux3_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && mode == MODE_MUX3) |-> (new_word[3] == old_word[3]));

    // R10: an idle block keeps its pointer
    p_idle_ptr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!txn_active && !txn_start) |=> $stable(data_ptr));

endmodule

// File: tb/dram_writer_tb_top.sv
`timescale 1ns/1ps
module dram_writer_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [2:0] hw_addr;
    logic       txn_start, txn_stop, cmd_valid;
    logic [2:0] cmd_op;
    logic [7:0] cmd_arg;
    logic [5:0] rd_addr;
    logic [3:0] rd_data;
    logic [5:0] data_ptr;
    logic       out_bank, txn_active;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    dram_writer dut_i (
        .clk, .rst_n, .hw_addr, .txn_start, .txn_stop, .cmd_valid, .cmd_op,
        .cmd_arg, .rd_addr, .rd_data, .data_ptr, .out_bank, .txn_active
    );

    typedef struct packed {
        logic [2:0] op;
        logic [7:0] arg;
        logic [5:0] raddr;
        logic [3:0] rd;
        logic [5:0] ptr;
        logic       ob;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 35;
    // op codes: 0 data, 1 devsel, 2 loadptr, 3 mode, 4 inbank, 5 outbank
    localparam vec_t VECS [NV] = '{
        '{3'd0, 8'h03, 6'd0,  4'h0, 6'd1,  1'b0, 4'd3},  // R3 blocked: subaddr 0, hw 5
        '{3'd1, 8'h05, 6'd0,  4'h0, 6'd1,  1'b0, 4'd2},  // R2 select 5
        '{3'd2, 8'h0A, 6'd10, 4'h0, 6'd10, 1'b0, 4'd4},
        '{3'd0, 8'h0A, 6'd10, 4'hA, 6'd11, 1'b0, 4'd7},  // R7 default 1:4
        '{3'd3, 8'h00, 6'd10, 4'hA, 6'd11, 1'b0, 4'd5},  // static
        '{3'd2, 8'h0A, 6'd10, 4'hA, 6'd10, 1'b0, 4'd4},
        '{3'd0, 8'h01, 6'd10, 4'hB, 6'd11, 1'b0, 4'd5},  // R5 bit0
        '{3'd4, 8'h01, 6'd10, 4'hB, 6'd11, 1'b0, 4'd8},
        '{3'd2, 8'h0A, 6'd10, 4'hB, 6'd10, 1'b0, 4'd4},
        '{3'd0, 8'h01, 6'd10, 4'hF, 6'd11, 1'b0, 4'd5},  // R5 bit2 set
        '{3'd2, 8'h0A, 6'd10, 4'hF, 6'd10, 1'b0, 4'd4},
        '{3'd0, 8'h00, 6'd10, 4'hB, 6'd11, 1'b0, 4'd5},  // R5 bit2 clear, bit0 kept
        '{3'd3, 8'h01, 6'd10, 4'hB, 6'd11, 1'b0, 4'd6},  // 1:2
        '{3'd0, 8'h02, 6'd11, 4'h8, 6'd12, 1'b0, 4'd6},  // R6 upper pair
        '{3'd4, 8'h00, 6'd11, 4'h8, 6'd12, 1'b0, 4'd8},
        '{3'd2, 8'h0B, 6'd11, 4'h8, 6'd11, 1'b0, 4'd4},
        '{3'd0, 8'h03, 6'd11, 4'hB, 6'd12, 1'b0, 4'd6},  // R6 lower pair
        '{3'd3, 8'h02, 6'd11, 4'hB, 6'd12, 1'b0, 4'd7},  // 1:3
        '{3'd4, 8'h01, 6'd11, 4'hB, 6'd12, 1'b0, 4'd7},
        '{3'd0, 8'h0F, 6'd12, 4'h7, 6'd13, 1'b0, 4'd7},  // R7 bit3 kept
        '{3'd2, 8'h0B, 6'd11, 4'hB, 6'd11, 1'b0, 4'd4},
        '{3'd0, 8'h0C, 6'd11, 4'hC, 6'd12, 1'b0, 4'd7},  // R7 bank ignored
        '{3'd3, 8'h03, 6'd11, 4'hC, 6'd12, 1'b0, 4'd7},
        '{3'd1, 8'h04, 6'd12, 4'h7, 6'd12, 1'b0, 4'd2},
        '{3'd0, 8'h05, 6'd12, 4'h7, 6'd13, 1'b0, 4'd3},  // R3 blocked, pointer moves
        '{3'd1, 8'h05, 6'd12, 4'h7, 6'd13, 1'b0, 4'd2},
        '{3'd2, 8'h27, 6'd39, 4'h0, 6'd39, 1'b0, 4'd4},
        '{3'd0, 8'h06, 6'd39, 4'h6, 6'd0,  1'b0, 4'd4},  // R4 wrap
        '{3'd2, 8'h28, 6'd39, 4'h6, 6'd0,  1'b0, 4'd4},  // R4 40 ignored
        '{3'd2, 8'h3F, 6'd39, 4'h6, 6'd0,  1'b0, 4'd4},
        '{3'd5, 8'h01, 6'd0,  4'h0, 6'd0,  1'b1, 4'd8},  // R8
        '{3'd4, 8'h00, 6'd0,  4'h0, 6'd0,  1'b1, 4'd8},
        '{3'd3, 8'h00, 6'd0,  4'h0, 6'd0,  1'b1, 4'd5},
        '{3'd0, 8'h01, 6'd0,  4'h1, 6'd1,  1'b1, 4'd8},  // in bank 0 despite out bank 1
        '{3'd3, 8'h03, 6'd0,  4'h1, 6'd1,  1'b1, 4'd7}
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic cmd(input logic [2:0] op, input logic [7:0] arg);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_arg = arg;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic pulse_start(input logic [2:0] a);
        @(negedge clk);
        hw_addr = a; txn_start = 1'b1;
        @(negedge clk);
        txn_start = 1'b0;
    endtask

    task automatic pulse_stop();
        @(negedge clk);
        txn_stop = 1'b1;
        @(negedge clk);
        txn_stop = 1'b0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            finish_run();
        end
    end

    initial begin
        rst_n = 1'b0; hw_addr = 3'd0; txn_start = 1'b0; txn_stop = 1'b0;
        cmd_valid = 1'b0; cmd_op = 3'd0; cmd_arg = 8'd0; rd_addr = 6'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(data_ptr == 6'd0, "R1 ptr", data_ptr, 0);
        chk(out_bank == 1'b0, "R1 out_bank", out_bank, 0);
        chk(txn_active == 1'b0, "R1 txn_active", txn_active, 0);
        for (int a = 0; a < 40; a++) begin
            rd_addr = 6'(a);
            #1;
            chk(rd_data == 4'h0, "R1 ram clear", rd_data, 0);
        end

        // R10 ignored while idle
        rd_addr = 6'd0;
        cmd(3'd0, 8'h0F);
        chk(data_ptr == 6'd0, "R10 idle data ptr", data_ptr, 0);
        chk(rd_data == 4'h0, "R10 idle data word", rd_data, 0);
        cmd(3'd5, 8'h01);
        chk(out_bank == 1'b0, "R10 idle outbank", out_bank, 0);

        pulse_start(3'd5);
        chk(txn_active == 1'b1, "R9 open", txn_active, 1);

        for (int i = 0; i < NV; i++) begin
            rd_addr = VECS[i].raddr;
            cmd(VECS[i].op, VECS[i].arg);
            if (data_ptr != VECS[i].ptr || rd_data != VECS[i].rd || out_bank != VECS[i].ob) begin
                n_chk++; n_fail++;
                $display("FAIL R%0d vec %0d actual ptr=%0d rd=0x%0h ob=%0d expected ptr=%0d rd=0x%0h ob=%0d",
                         VECS[i].req, i, data_ptr, rd_data, out_bank,
                         VECS[i].ptr, VECS[i].rd, VECS[i].ob);
            end else begin
                n_chk++;
            end
        end

        // R9: pins change mid-transaction, sampled value 5 still gates
        hw_addr = 3'd4;
        rd_addr = 6'd20;
        cmd(3'd2, 8'd20);
        cmd(3'd0, 8'h09);
        chk(rd_data == 4'h9, "R9 pin change ignored", rd_data, 9);
        chk(data_ptr == 6'd21, "R9 ptr", data_ptr, 21);

        // R9 / R2: reopen with address 4, subaddr 5 now mismatches
        pulse_stop();
        pulse_start(3'd4);
        rd_addr = 6'd21;
        cmd(3'd0, 8'h03);
        chk(rd_data == 4'h0, "R9 resampled blocks", rd_data, 0);
        chk(data_ptr == 6'd22, "R3 ptr after block", data_ptr, 22);
        cmd(3'd1, 8'h04);
        cmd(3'd2, 8'd21);
        cmd(3'd0, 8'h03);
        chk(rd_data == 4'h3, "R2 reselect stores", rd_data, 3);

        // R10 after close
        pulse_stop();
        chk(txn_active == 1'b0, "R10 closed", txn_active, 0);
        cmd(3'd2, 8'd5);
        chk(data_ptr == 6'd22, "R10 closed loadptr", data_ptr, 22);

        rd_addr = 6'd50;
        #1;
        chk(rd_data == 4'h0, "R4 read out of range", rd_data, 0);

        done = 1'b1;
        finish_run();
    end

endmodule